// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block produces the control signals of a processor by reading control words out of an on-chip control store instead of decoding them from logic. Every bit of the control word it outputs drives one control signal directly. A micro program counter selects the word. It steps forward by one each clock. It jumps to the first word of an instruction's micro-routine when the surrounding datapath strobes a new opcode into its instruction register. It returns to the shared fetch routine at address 0 when a word marks the end of a routine. It stalls on a word that waits for memory until memory reports that the function is complete.

The store holds 64 words of 24 bits. Its contents come from a rule inside the block. A fetch routine occupies the first three words, and each of the eight opcodes owns a fixed-size slot after it. The next word is read as the counter moves and is registered, so the output stays steady for the whole cycle.

Top module: `mpc_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the output becomes the word at address 0, and sequencing restarts there even in the middle of a routine.
- R2: The control word has this layout: bit 23 ends the routine, bit 22 waits for memory, bit 21 selects the ALU operand (1 picks the constant four, 0 picks register Y), bits 20:9 are zero, bits 8:6 carry the opcode tag, and bits 5:0 carry the word's own store address.
- R3: The fetch words sit at addresses 0, 1 and 2 with opcode tag 0. Only address 0 has the operand-select bit set. Only address 1 has the wait bit set. None of them has the end bit.
- R4: The routine for opcode k starts at address 3 + 7k and holds (k mod 4) + 2 words with opcode tag k and operand select 0. Only its last word has the end bit set. Store words outside the fetch words and all routines carry only the end bit and their address.
- R5: Among the routine words, the wait bit is set only on the second word of each routine for an odd opcode.
- R6: When `ir_load` is high at a clock edge, the next word is the first word of the routine for `opcode`. This has priority over the end bit and over a wait.
- R7: Without `ir_load`, a word with the end bit set is followed by the word at address 0.
- R8: Without `ir_load`, a word with the wait bit set repeats while `mfc_in` is low and advances by one address at the edge where `mfc_in` is high.
- R9: In all other cases, the address advances by one each clock. This includes leaving the fetch words at address 2 for address 3 when no opcode is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ir_load | input | 1 | New instruction entered the instruction register this cycle |
| opcode | input | OPC_W (3) | Opcode of the instruction being loaded |
| mfc_in | input | 1 | Memory function complete |
| ctrl_word | output | 24 | Current registered control word |

## Verification
The bench builds the block with its default parameters: a 6-bit micro address, 3-bit opcodes and a routine slot of seven words. This makes all eight routines reachable. Every opcode is run through fetch and routine with memory delays of zero to three cycles, which exercises every wait word with and without stalls. A patterned walk then loads opcodes from the end words, from stalled wait words and from the middle of routines. It also lets fetch fall through without a load and resets in mid-routine. Each output word is compared against a model of the stated store layout and sequencing rules.

// File: rtl/mpc_pkg.sv
`timescale 1ns/1ps
package mpc_pkg;

    localparam int CW_W      = 24;
    localparam int TAG_W     = 6;
    localparam int OPC_TAG_W = 3;
    localparam int SPARE_W   = CW_W - 3 - OPC_TAG_W - TAG_W;

    // Field order matters: the sequencer decodes the top two bits.
    typedef struct packed {
        logic                 end_step;
        logic                 wait_mem;
        logic                 sel_four;
        logic [SPARE_W-1:0]   spare;
        logic [OPC_TAG_W-1:0] opc_tag;
        logic [TAG_W-1:0]     addr_tag;
    } cword_t;

    typedef enum logic [1:0] {
        NX_LOAD,
        NX_HOME,
        NX_HOLD,
        NX_STEP
    } nxt_sel_e;

    function automatic int routine_len(input int k);
        return (k % 4) + 2;
    endfunction

    // Content rule of the control store.
    function automatic cword_t store_word(input int addr, input int fetch_len,
                                          input int span, input int n_opc);
        cword_t w;
        int rel;
        int k;
        int off;
        w = '0;
        w.addr_tag = TAG_W'(addr);
        if (addr < fetch_len) begin
            w.sel_four = (addr == 0);
            w.wait_mem = (addr == 1);
        end else begin
            rel = addr - fetch_len;
            k   = rel / span;
            off = rel % span;
            if (k >= n_opc || off >= routine_len(k)) begin
                w.end_step = 1'b1;
            end else begin
                w.opc_tag  = OPC_TAG_W'(k);
                w.wait_mem = ((k % 2) == 1) && (off == 1);
                w.end_step = (off == routine_len(k) - 1);
            end
        end
        return w;
    endfunction

endpackage

// File: rtl/mpc_start_table.sv
`timescale 1ns/1ps
module mpc_start_table #(
    parameter int ADDR_W    = 6,
    parameter int OPC_W     = 3,
    parameter int FETCH_LEN = 3,
    parameter int SPAN      = 7
) (
    input  logic [OPC_W-1:0]  opcode,
    output logic [ADDR_W-1:0] start_addr
);
    localparam int N_OPC = 1 << OPC_W;

    logic [ADDR_W-1:0] table_q [N_OPC];

    for (genvar g = 0; g < N_OPC; g++) begin : g_entry
        assign table_q[g] = ADDR_W'(FETCH_LEN + g * SPAN);
    end

    assign start_addr = table_q[opcode];
endmodule

// File: rtl/mpc_ctrl_store.sv
`timescale 1ns/1ps
module mpc_ctrl_store
    import mpc_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int FETCH_LEN = 3,
    parameter int SPAN      = 7,
    parameter int N_OPC     = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output cword_t            word
);
    localparam int DEPTH = 1 << ADDR_W;

    cword_t rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign rom[g] = store_word(g, FETCH_LEN, SPAN, N_OPC);
    end

    assign word = rom[addr];
endmodule

// File: rtl/mpc_next_addr.sv
`timescale 1ns/1ps
module mpc_next_addr
    import mpc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  cword_t            cur_word,
    input  logic              ir_load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              mfc_in,
    output logic [ADDR_W-1:0] nxt_addr,
    output nxt_sel_e          nxt_sel
);
    always_comb begin
        if (ir_load)
            nxt_sel = NX_LOAD;
        else if (cur_word.end_step)
            nxt_sel = NX_HOME;
        else if (cur_word.wait_mem && !mfc_in)
            nxt_sel = NX_HOLD;
        else
            nxt_sel = NX_STEP;
    end

    always_comb begin
        unique case (nxt_sel)
            NX_LOAD: nxt_addr = start_addr;
            NX_HOME: nxt_addr = '0;
            NX_HOLD: nxt_addr = cur_addr;
            default: nxt_addr = cur_addr + ADDR_W'(1);
        endcase
    end
endmodule

// File: rtl/mpc_sequencer.sv
`timescale 1ns/1ps
module mpc_sequencer
    import mpc_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int OPC_W     = 3,
    parameter int FETCH_LEN = 3,
    parameter int SPAN      = 7
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ir_load,
    input  logic [OPC_W-1:0]        opcode,
    input  logic                    mfc_in,
    output logic [mpc_pkg::CW_W-1:0] ctrl_word
);
    localparam int N_OPC = 1 << OPC_W;

    logic [ADDR_W-1:0] upc_q;
    cword_t            cw_q;
    logic [ADDR_W-1:0] start_addr;
    logic [ADDR_W-1:0] nxt_addr;
    logic [ADDR_W-1:0] rd_addr;
    nxt_sel_e          nxt_sel;
    cword_t            rd_word;

    mpc_start_table #(
        .ADDR_W(ADDR_W), .OPC_W(OPC_W), .FETCH_LEN(FETCH_LEN), .SPAN(SPAN)
    ) u_start (
        .opcode    (opcode),
        .start_addr(start_addr)
    );

    mpc_next_addr #(.ADDR_W(ADDR_W)) u_next (
        .cur_addr  (upc_q),
        .cur_word  (cw_q),
        .ir_load   (ir_load),
        .start_addr(start_addr),
        .mfc_in    (mfc_in),
        .nxt_addr  (nxt_addr),
        .nxt_sel   (nxt_sel)
    );

    assign rd_addr = rst ? '0 : nxt_addr;

    mpc_ctrl_store #(
        .ADDR_W(ADDR_W), .FETCH_LEN(FETCH_LEN), .SPAN(SPAN), .N_OPC(N_OPC)
    ) u_store (
        .addr(rd_addr),
        .word(rd_word)
    );

    always_ff @(posedge clk) begin
        upc_q <= rd_addr;
        cw_q  <= rd_word;
    end

    assign ctrl_word = cw_q;

    logic unused_sel;
    assign unused_sel = ^nxt_sel;
endmodule

// File: rtl/mpc_sequencer_chk.sv
`timescale 1ns/1ps
module mpc_sequencer_chk
    import mpc_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int OPC_W     = 3,
    parameter int FETCH_LEN = 3,
    parameter int SPAN      = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              ir_load,
    input logic [OPC_W-1:0]  opcode,
    input logic              mfc_in,
    input logic [CW_W-1:0]   ctrl_word
);
    cword_t cw;
    assign cw = cword_t'(ctrl_word);

    // R1
    reset_home_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> cw.addr_tag == '0);

    // R6
    load_jump_chk: assert property (@(posedge clk) disable iff (rst)
        ir_load |=> cw.addr_tag == TAG_W'(FETCH_LEN + int'($past(opcode)) * SPAN));

    // R7
    end_home_chk: assert property (@(posedge clk) disable iff (rst)
        (!ir_load && cw.end_step) |=> cw.addr_tag == '0);

    // R8
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ir_load && !cw.end_step && cw.wait_mem && !mfc_in) |=> $stable(ctrl_word));

    // R9
    step_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (!ir_load && !cw.end_step && (!cw.wait_mem || mfc_in))
        |=> cw.addr_tag == TAG_W'($past(cw.addr_tag) + 1'b1));

    // R2
    spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cw.spare == '0);
endmodule

bind mpc_sequencer mpc_sequencer_chk #(
    .ADDR_W(ADDR_W), .OPC_W(OPC_W), .FETCH_LEN(FETCH_LEN), .SPAN(SPAN)
) u_chk (
    .clk(clk), .rst(rst), .ir_load(ir_load), .opcode(opcode),
    .mfc_in(mfc_in), .ctrl_word(ctrl_word)
);

// File: tb/tb_mpc_sequencer.sv
`timescale 1ns/1ps
module tb_mpc_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ir_load = 1'b0;
    logic [2:0]  opcode = '0;
    logic        mfc_in = 1'b0;
    logic [23:0] ctrl_word;

    int n_vec  = 0;
    int n_fail = 0;
    int ea     = 0;

    always #5 clk = ~clk;

    mpc_sequencer dut (
        .clk(clk), .rst(rst), .ir_load(ir_load), .opcode(opcode),
        .mfc_in(mfc_in), .ctrl_word(ctrl_word)
    );

    // Expected word from the stated layout: R2 fields, R3 fetch, R4 routines, R5 waits.
    function automatic logic [23:0] ew(input int a);
        logic [23:0] w;
        int k;
        int o;
        int len;
        w = '0;
        w[5:0] = 6'(a);
        if (a < 3) begin
            w[21] = (a == 0);
            w[22] = (a == 1);
        end else begin
            k = (a - 3) / 7;
            o = (a - 3) % 7;
            len = (k % 4) + 2;
            if (k > 7 || o >= len) begin
                w[23] = 1'b1;
            end else begin
                w[8:6] = 3'(k);
                w[22]  = ((k % 2) == 1) && (o == 1);
                w[23]  = (o == len - 1);
            end
        end
        return w;
    endfunction

    task automatic check(input logic [23:0] exp, input string tag);
        n_vec++;
        if (ctrl_word !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, ctrl_word, exp);
        end
    endtask

    task automatic cyc(input logic ld, input int opc, input logic mfc);
        logic [23:0] w;
        int nxt;
        string rule;
        string cont;
        @(negedge clk);
        ir_load = ld;
        opcode  = 3'(opc);
        mfc_in  = mfc;
        w = ew(ea);
        if (ld) begin
            nxt = 3 + 7 * opc;  rule = "R6";
        end else if (w[23]) begin
            nxt = 0;            rule = "R7";
        end else if (w[22] && !mfc) begin
            nxt = ea;           rule = "R8";
        end else begin
            nxt = (ea + 1) % 64;
            rule = w[22] ? "R8" : "R9";
        end
        cont = (nxt < 3) ? "R3" : (ew(nxt)[22] ? "R5" : "R4");
        @(posedge clk);
        #2;
        ea = nxt;
        check(ew(nxt), $sformatf("%s %s R2 addr=%0d", rule, cont, nxt));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ir_load = 1'b0;
        mfc_in = 1'b0;
        @(posedge clk);
        #2;
        ea = 0;
        check(ew(0), "R1 reset word");
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_instr(input int opc, input int d);
        logic [23:0] w;
        cyc(1'b0, 0, 1'b0);
        for (int i = 0; i < d; i++) cyc(1'b0, 0, 1'b0);
        cyc(1'b0, 0, 1'b1);
        cyc(1'b1, opc, 1'b0);
        for (int s = 0; s < 10; s++) begin
            w = ew(ea);
            if (w[23]) begin
                cyc(1'b0, 0, 1'b0);
                break;
            end
            if (w[22]) begin
                for (int i = 0; i < d; i++) cyc(1'b0, 0, 1'b0);
                cyc(1'b0, 0, 1'b1);
            end else begin
                cyc(1'b0, 0, 1'b0);
            end
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        @(posedge clk);
        @(posedge clk);
        #2;
        check(ew(0), "R1 reset word");
        @(negedge clk);
        rst = 1'b0;

        // Every opcode, memory delays 0..3 (R3 R4 R5 R6 R7 R8 R9)
        for (int opc = 0; opc < 8; opc++)
            for (int d = 0; d < 4; d++)
                run_instr(opc, d);

        // R9: fetch falls through into address 3 without a load
        cyc(1'b0, 0, 1'b1);
        cyc(1'b0, 0, 1'b1);
        cyc(1'b0, 0, 1'b0);
        cyc(1'b0, 0, 1'b0);
        cyc(1'b0, 0, 1'b0);

        // R6 priority: load while stalled on fetch wait word
        cyc(1'b0, 0, 1'b0);
        cyc(1'b1, 6, 1'b0);
        // R6 priority: load on an end word
        while (!ew(ea)[23]) cyc(1'b0, 0, 1'b1);
        cyc(1'b1, 3, 1'b0);
        // R6 priority: load on a stalled routine wait word
        cyc(1'b0, 0, 1'b0);
        cyc(1'b1, 1, 1'b0);

        // Patterned walk
        for (int i = 0; i < 200; i++)
            cyc((i % 9) == 4, (i * 5) % 8, (i % 3) != 0);

        // R1: reset mid-routine
        cyc(1'b1, 7, 1'b0);
        cyc(1'b0, 0, 1'b0);
        do_reset();
        run_instr(5, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule